// File: doc/BRIEF.md
# Lifetime Usage Counter

This peripheral keeps a running record of how long a host processor has been in use. A prescaler divides the host clock, and each time it wraps, one unit is added to a usage count held in a modelled nonvolatile word. A small register with a write-completion delay stands in for the real storage cell. The count can only grow. No reset, bus command or other input can clear it, load it or lower it. Once it reaches all ones it stays there instead of wrapping.

The same storage also holds a fixed identity number. The host reaches both values only through a read-only SPI slave (mode 0, MSB first). The host is expected to poll the identity number from time to time and to stop itself if the answer is wrong. Each identity read is therefore also counted: it adds one to the stored count on top of the clock-derived units. A system reset clears only the prescaler and the SPI receive state. The stored count survives it.

Top module: `usage_meter`

## Requirements
- R1: Opcode 0x01 returns the SERIAL_W-bit identity number SERIAL_ID, MSB first, on the SPI data bits that follow the 8-bit opcode. The opcode is sampled on SCLK rising edges and MISO changes on falling edges (mode 0).
- R2: Opcode 0x02 returns the COUNT_W-bit stored usage count, MSB first, in the same framing. A fresh part reads zero.
- R3: Every identity read (opcode 0x01) adds exactly one to the stored count. A count read (opcode 0x02) adds nothing.
- R4: Any other opcode returns all-zero data bits and leaves the stored count unchanged.
- R5: While reset is low, the count gains one for every 2^PRESC_W host clock cycles.
- R6: When a prescaler increment and an identity-read increment fall in the same cycle, both are applied, for a net gain of two.
- R7: The count saturates at all ones and never wraps, not even under further identity reads.
- R8: Reset restarts the prescaler from zero and clears the SPI state (MISO low). It leaves the stored count unchanged.
- R9: The count value sent in a frame is captured when the opcode completes. An increment that lands during the data bits does not alter the bits being sent.
- R10: The stored count never decreases from one cycle to the next.
- R11: MISO is driven low while chip select has been high for three or more clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock, also the clock being counted |
| rst | input | 1 | Synchronous active-high reset (prescaler and SPI only) |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from the host (opcode) |
| spi_miso | output | 1 | SPI data to the host, registered |

## Verification
The SPI pins pass through a two-stage synchronizer and an edge register, so each SCLK edge takes effect on the third rising clock edge after it. MISO is therefore valid within three cycles of a falling SCLK. The bench holds each SCLK level for five cycles and samples MISO just before raising SCLK. An identity read raises the poll increment about 78 cycles after chip select falls. An increment reaches the readable count WR_LAT+1 or more cycles after it happens. The first prescaler increment after reset is due at cycle 2^PRESC_W. Each count read is placed either well before that cycle or well after its commit, except in the capture test, where the wrap is placed on purpose between opcode capture and the end of the data bits. The coincidence test sweeps the start time of an identity read across the wrap cycle and expects exactly plus two each time.

// File: rtl/usage_pkg.sv
package usage_pkg;
  localparam int OP_W = 8;
  localparam logic [OP_W-1:0] OP_RD_IDENT = 8'h01;
  localparam logic [OP_W-1:0] OP_RD_USAGE = 8'h02;
endpackage

// File: rtl/usage_prescaler.sv
module usage_prescaler #(
  parameter int PRESC_W = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [PRESC_W-1:0] div_q;

  // tick is a one-cycle pulse issued when the divider wraps
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else begin
      div_q <= div_q + 1'b1;
      tick  <= &div_q;
    end
  end
endmodule

// File: rtl/usage_nvstore.sv
module usage_nvstore #(
  parameter int COUNT_W = 48,
  parameter int SERIAL_W = 32,
  parameter logic [SERIAL_W-1:0] SERIAL_ID = 32'hA5C3_1E97,
  parameter int WR_LAT = 4
) (
  input  logic                clk,
  input  logic                inc_tick,
  input  logic                inc_poll,
  output logic [COUNT_W-1:0]  count_o,
  output logic [SERIAL_W-1:0] serial_o
);
  localparam int TW = $clog2(WR_LAT + 1);

  // Nonvolatile model: no reset input reaches any of this state.
  logic [COUNT_W-1:0] cell_q = '0;
  logic [COUNT_W-1:0] pend_q = '0;
  logic [COUNT_W-1:0] wr_data_q = '0;
  logic               wr_busy_q = 1'b0;
  logic [TW-1:0]      wr_left_q = '0;

  function automatic logic [COUNT_W-1:0] sat_add(input logic [COUNT_W-1:0] a,
                                                 input logic [COUNT_W-1:0] b);
    logic [COUNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[COUNT_W] ? {COUNT_W{1'b1}} : s[COUNT_W-1:0];
  endfunction

  logic [COUNT_W-1:0] inc_now;
  logic               wr_start;

  assign inc_now  = COUNT_W'(inc_tick) + COUNT_W'(inc_poll);
  assign wr_start = !wr_busy_q && (pend_q != '0);

  always_ff @(posedge clk) begin
    // pending increments gather here while a write is in flight
    pend_q <= wr_start ? inc_now : sat_add(pend_q, inc_now);
    if (wr_start) begin
      wr_data_q <= sat_add(cell_q, pend_q);
      wr_busy_q <= 1'b1;
      wr_left_q <= TW'(WR_LAT);
    end else if (wr_busy_q) begin
      if (wr_left_q == TW'(1)) begin
        cell_q    <= wr_data_q;
        wr_busy_q <= 1'b0;
      end
      wr_left_q <= wr_left_q - 1'b1;
    end
  end

  assign count_o  = cell_q;
  assign serial_o = SERIAL_ID;
endmodule

// File: rtl/usage_spi_slave.sv
module usage_spi_slave
  import usage_pkg::*;
#(
  parameter int SERIAL_W = 32,
  parameter int COUNT_W = 48
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                mosi,
  input  logic [SERIAL_W-1:0] serial_i,
  input  logic [COUNT_W-1:0]  count_i,
  output logic                miso,
  output logic                poll_o
);
  localparam int DATA_W = (SERIAL_W > COUNT_W) ? SERIAL_W : COUNT_W;
  localparam int BIT_W  = $clog2(OP_W);

  logic [2:0] sclk_s;
  logic [1:0] cs_s;
  logic [1:0] mosi_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      cs_s   <= {cs_s[0], cs_n};
      mosi_s <= {mosi_s[0], mosi};
    end
  end

  logic sclk_rise, sclk_fall, selected;
  assign sclk_rise = sclk_s[1] & ~sclk_s[2];
  assign sclk_fall = ~sclk_s[1] & sclk_s[2];
  assign selected  = ~cs_s[1];

  logic [OP_W-2:0]   op_sr;
  logic [OP_W-1:0]   op_word;
  logic [BIT_W-1:0]  bit_cnt;
  logic              op_done;
  logic [DATA_W-1:0] data_sr;

  assign op_word = {op_sr, mosi_s[1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      op_sr   <= '0;
      bit_cnt <= '0;
      op_done <= 1'b0;
      data_sr <= '0;
      miso    <= 1'b0;
      poll_o  <= 1'b0;
    end else begin
      poll_o <= 1'b0;
      if (!selected) begin
        bit_cnt <= '0;
        op_done <= 1'b0;
        miso    <= 1'b0;
      end else if (!op_done) begin
        if (sclk_rise) begin
          op_sr   <= op_word[OP_W-2:0];
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == BIT_W'(OP_W - 1)) begin
            op_done <= 1'b1;
            // the reply is captured here and held for the whole frame
            case (op_word)
              OP_RD_IDENT: begin
                data_sr <= DATA_W'(serial_i) << (DATA_W - SERIAL_W);
                poll_o  <= 1'b1;
              end
              OP_RD_USAGE: data_sr <= DATA_W'(count_i) << (DATA_W - COUNT_W);
              default:     data_sr <= '0;
            endcase
          end
        end
      end else if (sclk_fall) begin
        miso    <= data_sr[DATA_W-1];
        data_sr <= data_sr << 1;
      end
    end
  end
endmodule

// File: rtl/usage_meter.sv
module usage_meter #(
  parameter int PRESC_W = 16,
  parameter int COUNT_W = 48,
  parameter int SERIAL_W = 32,
  parameter logic [SERIAL_W-1:0] SERIAL_ID = 32'hA5C3_1E97,
  parameter int WR_LAT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  logic                presc_tick;
  logic                poll_pulse;
  logic [COUNT_W-1:0]  nv_count;
  logic [SERIAL_W-1:0] nv_serial;

  usage_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk (clk),
    .rst (rst),
    .tick(presc_tick)
  );

  usage_nvstore #(
    .COUNT_W  (COUNT_W),
    .SERIAL_W (SERIAL_W),
    .SERIAL_ID(SERIAL_ID),
    .WR_LAT   (WR_LAT)
  ) u_store (
    .clk     (clk),
    .inc_tick(presc_tick),
    .inc_poll(poll_pulse),
    .count_o (nv_count),
    .serial_o(nv_serial)
  );

  usage_spi_slave #(.SERIAL_W(SERIAL_W), .COUNT_W(COUNT_W)) u_spi (
    .clk     (clk),
    .rst     (rst),
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .serial_i(nv_serial),
    .count_i (nv_count),
    .miso    (spi_miso),
    .poll_o  (poll_pulse)
  );
endmodule

// File: rtl/usage_meter_chk.sv
module usage_meter_chk #(
  parameter int COUNT_W = 48
) (
  input logic               clk,
  input logic               rst,
  input logic               cs_n,
  input logic               miso,
  input logic               tick,
  input logic               poll,
  input logic [COUNT_W-1:0] count
);
  logic [1:0] age = '0;
  logic       warm;
  always_ff @(posedge clk) if (age != 2'd3) age <= age + 2'd1;
  assign warm = (age == 2'd3);

  // R10: the count never goes down
  a_r10_count_monotonic: assert property (@(posedge clk) disable iff (!warm)
    count >= $past(count));

  // R7: once saturated, the count stays at all ones
  a_r7_saturation_holds: assert property (@(posedge clk) disable iff (!warm)
    (count == {COUNT_W{1'b1}}) |=> (count == {COUNT_W{1'b1}}));

  // R11: MISO is low once chip select has been high for three cycles
  a_r11_miso_idle: assert property (@(posedge clk) disable iff (rst || !warm)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |=> !miso);

  // R5: the prescaler increment is a single-cycle pulse
  a_r5_tick_single: assert property (@(posedge clk) disable iff (rst || !warm)
    tick |=> !tick);

  // R3: one identity read raises one single-cycle increment request
  a_r3_poll_single: assert property (@(posedge clk) disable iff (rst || !warm)
    poll |=> !poll);
endmodule

bind usage_meter usage_meter_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .cs_n (spi_cs_n),
  .miso (spi_miso),
  .tick (presc_tick),
  .poll (poll_pulse),
  .count(nv_count)
);

// File: tb/tb_usage_meter.sv
`timescale 1ns/1ps
module tb_usage_meter;
  localparam int H = 5;
  localparam logic [31:0] ID = 32'hA5C3_1E97;
  localparam int WD = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, mosi = 1'b0, cs0_n = 1'b1, cs1_n = 1'b1;
  logic miso0, miso1;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [63:0] rx;
  logic [63:0] exp_cnt;

  always #2 clk = ~clk;

  usage_meter #(.PRESC_W(12), .SERIAL_ID(ID)) dut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs0_n),
    .spi_mosi(mosi), .spi_miso(miso0));

  usage_meter #(.PRESC_W(2), .COUNT_W(10), .SERIAL_ID(ID)) dut_sat (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs1_n),
    .spi_mosi(mosi), .spi_miso(miso1));

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] expv);
    n_run++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input bit sel, input logic [7:0] op, input int nbits,
                      output logic [63:0] data);
    data = '0;
    @(negedge clk);
    if (sel) cs1_n = 1'b0; else cs0_n = 1'b0;
    for (int i = 0; i < 8 + nbits; i++) begin
      mosi = (i < 8) ? op[7-i] : 1'b0;
      wait_cyc(H);
      if (i >= 8) data = {data[62:0], (sel ? miso1 : miso0)};
      sclk = 1'b1;
      wait_cyc(H);
      sclk = 1'b0;
    end
    wait_cyc(H);
    cs0_n = 1'b1;
    cs1_n = 1'b1;
    wait_cyc(H);
  endtask

  task automatic t_reset_state();
    do_reset();
    wait_cyc(4);
    check("R8/R11 miso low after reset", {63'd0, miso0}, 64'd0);
    check("R11 second unit miso low", {63'd0, miso1}, 64'd0);
  endtask

  task automatic t_ident_reads();
    do_reset();
    xfer(0, 8'h02, 48, rx); check("R2 fresh count is zero", rx, 64'd0);
    xfer(0, 8'h01, 32, rx); check("R1 identity value", rx, {32'd0, ID});
    xfer(0, 8'h02, 48, rx); check("R3 identity read adds one", rx, 64'd1);
    xfer(0, 8'h01, 32, rx);
    xfer(0, 8'h01, 32, rx); check("R1 identity repeated", rx, {32'd0, ID});
    xfer(0, 8'h02, 48, rx); check("R3 two more reads, count reads add none", rx, 64'd3);
  endtask

  task automatic t_unknown_op();
    do_reset();
    xfer(0, 8'h5A, 48, rx); check("R4 unknown opcode returns zeros", rx, 64'd0);
    xfer(0, 8'hFF, 48, rx); check("R4 opcode ff returns zeros", rx, 64'd0);
    xfer(0, 8'h02, 48, rx); check("R4 count untouched by unknown opcodes", rx, 64'd3);
  endtask

  task automatic t_reset_keeps();
    do_reset();
    do_reset();
    xfer(0, 8'h02, 48, rx); check("R8/R10 count kept across reset", rx, 64'd3);
  endtask

  task automatic t_prescale();
    do_reset();
    wait_cyc(4096 + 100);
    xfer(0, 8'h02, 48, rx); check("R5 one unit after 2^PRESC_W cycles", rx, 64'd4);
    do_reset();
    wait_cyc(3000);
    do_reset();
    wait_cyc(3000);
    xfer(0, 8'h02, 48, rx); check("R8 reset restarts prescaler", rx, 64'd4);
  endtask

  task automatic t_capture();
    do_reset();
    wait_cyc(3800);
    xfer(0, 8'h02, 48, rx); check("R9 value captured at opcode", rx, 64'd4);
    xfer(0, 8'h02, 48, rx); check("R9 later read sees the unit", rx, 64'd5);
  endtask

  task automatic t_coincide();
    exp_cnt = 64'd5;
    for (int k = 0; k < 20; k++) begin
      do_reset();
      wait_cyc(4006 + k);
      xfer(0, 8'h01, 32, rx);
      xfer(0, 8'h02, 48, rx);
      exp_cnt = exp_cnt + 64'd2;
      check($sformatf("R6 tick plus poll offset %0d", k), rx, exp_cnt);
    end
  endtask

  task automatic t_saturate();
    xfer(1, 8'h02, 10, rx); check("R7 count saturated", rx, 64'h3FF);
    xfer(1, 8'h01, 32, rx); check("R1 identity on saturated unit", rx, {32'd0, ID});
    xfer(1, 8'h02, 10, rx); check("R7 no wrap after poll", rx, 64'h3FF);
  endtask

  initial begin
    t_reset_state();
    t_ident_reads();
    t_unknown_op();
    t_reset_keeps();
    t_prescale();
    t_capture();
    t_coincide();
    t_saturate();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule